// File: doc/BRIEF.md
# Output Delay Tap Controller

This block keeps the tap setting that steers a programmable output delay line of 512 taps. It does not model the analog delay; it holds the 9-bit count that such a delay line would use. A control clock samples three strobes: load, clock-enable and increment. A build-time parameter picks one of three operating types. In fixed type the setting never moves. In step type each enable strobe moves the setting one tap up or down. In load type a load strobe copies a new count from the input port, and enable strobes still step it.

A second parameter picks the update policy. This decides when a new value reaches the active setting. Under the immediate policy, an accepted request changes the active setting at once. Under the data-edge policy, requests go into a staging register, and the staged value becomes active on the next transition of the data bit that passes through the delay line. Under the manual policy, requests are also staged. The staged value becomes active only on a later cycle in which load and clock-enable are both high.

A hold input freezes the setting while an external tracking loop owns the delay line. A dedicated delay reset and the block reset both return the setting to a configured initial value. That value is clamped to the 9-bit range. The active setting can always be read on a monitor port.

Top module: `odly_tap_ctrl`

## Requirements
- R1: The active tap setting is an unsigned TAP_W-bit count (default 9 bits, taps 0 to 511), and it appears on `tap_mon` in every cycle.
- R2: While `hold_en` is high, no request and no commit is accepted, so `tap_mon` does not change except through `dly_rst`.
- R3: In step type, a cycle with `ce` high moves the setting one tap: up when `inc` is 1 and down when `inc` is 0. `load` has no effect in this type.
- R4: In load type, a cycle with `load` high copies `tap_in` into the setting. A cycle with `ce` high and `load` low steps the setting as in R3.
- R5: In fixed type, `tap_mon` always equals the initial value, whatever strobes arrive.
- R6: A cycle with `dly_rst` high returns both the active and the staged setting to the initial value on the next edge. This overrides hold and every strobe.
- R7: Under the manual policy, requests change only the staged value. A cycle with `load` and `ce` both high (and `hold_en` low) copies the staged value into the active setting. That commit cycle makes no other change.
- R8: Under the data-edge policy, requests change only the staged value. The active setting takes the staged value in any cycle where `line_data` differs from its value on the previous clock, provided `hold_en` is low.
- R9: The initial value is INIT_TAP, clamped to 2^TAP_W-1. It is applied by the asynchronous reset `rst_n` as well as by `dly_rst`.
- R10: Stepping saturates: down from 0 stays at 0, and up from 511 stays at 511.
- R11: In load type, when `load` and `ce` are high in the same cycle (outside a manual commit), the load wins and the setting becomes `tap_in`.
- R12: Under the immediate policy, an accepted request appears on `tap_mon` one clock edge after the cycle in which it was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset to the initial value |
| dly_rst | input | 1 | Synchronous return of the setting to the initial value |
| hold_en | input | 1 | Freeze the setting while high |
| ce | input | 1 | Step enable; forms the commit strobe together with `load` under the manual policy |
| inc | input | 1 | Step direction, 1 = up, 0 = down |
| load | input | 1 | Copy `tap_in` (load type) or commit (with `ce`, manual policy) |
| tap_in | input | TAP_W | Count to be loaded |
| line_data | input | 1 | Data bit passing through the delay line; its transitions commit under the data-edge policy |
| tap_mon | output | TAP_W | Active tap setting |

## Verification
The main function is tried in two ways. First, a directed walk drives the setting into both rails, which separates saturation from wraparound. Runs of enable-only strobes are then compared across instances built with different types and policies. This shows whether a step reaches the active setting or only the staged one. A cycle with load and enable together tells load priority apart from a manual commit. A hold window that carries live strobes shows whether hold really blocks them. After that, a long random mix of strobes, hold, delay reset and data toggles runs on five instances (every type and every policy). The mix includes load values biased toward 0 and 511. Each instance is compared every cycle with a bench model built from the requirements.

// File: rtl/odly_pkg.sv
package odly_pkg;

   // How the tap setting may be changed
   typedef enum logic [1:0] {
      DLY_FIXED = 2'd0,
      DLY_STEP  = 2'd1,
      DLY_LOAD  = 2'd2
   } dly_kind_e;

   // When a requested value becomes the active setting
   typedef enum logic [1:0] {
      UPD_NOW    = 2'd0,
      UPD_EDGE   = 2'd1,
      UPD_MANUAL = 2'd2
   } upd_policy_e;

endpackage

// File: rtl/odly_edge_det.sv
module odly_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic line_data,
   output logic line_edge
);

   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_data;
   end

   assign line_edge = line_data ^ line_q;

endmodule

// File: rtl/odly_req_dec.sv
module odly_req_dec
   import odly_pkg::*;
#(
   parameter int          TAP_W  = 9,
   parameter dly_kind_e   KIND   = DLY_LOAD,
   parameter upd_policy_e POLICY = UPD_NOW
) (
   input  logic             hold_en,
   input  logic             ce,
   input  logic             inc,
   input  logic             load,
   input  logic [TAP_W-1:0] tap_in,
   input  logic [TAP_W-1:0] base,
   output logic             upd_vld,
   output logic [TAP_W-1:0] upd_val,
   output logic             commit
);

   localparam logic [TAP_W-1:0] TAP_TOP = '1;
   localparam logic [TAP_W-1:0] TAP_ONE = TAP_W'(1);

   logic [TAP_W-1:0] stepped;
   logic             man_commit;

   // Saturating one-tap move from the staging base
   always_comb begin
      if (inc) stepped = (base == TAP_TOP) ? base : base + TAP_ONE;
      else     stepped = (base == '0)      ? base : base - TAP_ONE;
   end

   generate
      if (POLICY == UPD_MANUAL) begin : g_man
         assign man_commit = load & ce & ~hold_en;
      end else begin : g_auto
         assign man_commit = 1'b0;
      end
   endgenerate

   generate
      if (KIND == DLY_FIXED) begin : g_fixed
         logic unused_fixed;
         assign unused_fixed = ^{ce, inc, load, tap_in, stepped, man_commit, hold_en};
         assign upd_vld = 1'b0;
         assign upd_val = base;
         assign commit  = 1'b0;
      end else if (KIND == DLY_STEP) begin : g_step
         logic unused_step;
         assign unused_step = ^tap_in;
         assign upd_vld = ce & ~hold_en & ~man_commit;
         assign upd_val = stepped;
         assign commit  = man_commit;
      end else begin : g_load
         assign upd_vld = (ce | load) & ~hold_en & ~man_commit;
         assign upd_val = load ? tap_in : stepped;
         assign commit  = man_commit;
      end
   endgenerate

endmodule

// File: rtl/odly_tap_regs.sv
module odly_tap_regs
   import odly_pkg::*;
#(
   parameter int               TAP_W    = 9,
   parameter logic [TAP_W-1:0] INIT_VAL = '0,
   parameter upd_policy_e      POLICY   = UPD_NOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dly_rst,
   input  logic             hold_en,
   input  logic             upd_vld,
   input  logic [TAP_W-1:0] upd_val,
   input  logic             commit,
   input  logic             line_edge,
   output logic [TAP_W-1:0] act_q,
   output logic [TAP_W-1:0] pend_q
);

   generate
      if (POLICY == UPD_NOW) begin : g_now
         logic unused_now;
         assign unused_now = ^{hold_en, commit, line_edge};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       act_q <= INIT_VAL;
            else if (dly_rst) act_q <= INIT_VAL;
            else if (upd_vld) act_q <= upd_val;
         end
         assign pend_q = act_q;
      end else begin : g_staged
         logic take;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend_q <= INIT_VAL;
            else if (dly_rst) pend_q <= INIT_VAL;
            else if (upd_vld) pend_q <= upd_val;
         end

         if (POLICY == UPD_EDGE) begin : g_edge
            logic unused_edge;
            assign unused_edge = commit;
            assign take = line_edge & ~hold_en;
         end else begin : g_manual
            logic unused_man;
            assign unused_man = line_edge;
            assign take = commit;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       act_q <= INIT_VAL;
            else if (dly_rst) act_q <= INIT_VAL;
            else if (take)    act_q <= pend_q;
         end
      end
   endgenerate

endmodule

// File: rtl/odly_tap_ctrl.sv
module odly_tap_ctrl
   import odly_pkg::*;
#(
   parameter int          TAP_W    = 9,
   parameter int          INIT_TAP = 0,
   parameter dly_kind_e   KIND     = DLY_LOAD,
   parameter upd_policy_e POLICY   = UPD_NOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dly_rst,
   input  logic             hold_en,
   input  logic             ce,
   input  logic             inc,
   input  logic             load,
   input  logic [TAP_W-1:0] tap_in,
   input  logic             line_data,
   output logic [TAP_W-1:0] tap_mon
);

   localparam int               TAP_MAX  = (1 << TAP_W) - 1;
   localparam int               INIT_SAT = (INIT_TAP > TAP_MAX) ? TAP_MAX : INIT_TAP;
   localparam logic [TAP_W-1:0] INIT_VAL = INIT_SAT[TAP_W-1:0];

   generate
      if (TAP_W < 2 || TAP_W > 16) begin : g_bad_width
         $error("odly_tap_ctrl: TAP_W must lie in 2..16");
      end
      if (INIT_TAP < 0) begin : g_bad_init
         $error("odly_tap_ctrl: INIT_TAP must not be negative");
      end
   endgenerate

   logic             upd_vld;
   logic [TAP_W-1:0] upd_val;
   logic             commit;
   logic             line_edge;
   logic [TAP_W-1:0] act_q;
   logic [TAP_W-1:0] pend_q;

   odly_edge_det u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_data (line_data),
      .line_edge (line_edge)
   );

   odly_req_dec #(
      .TAP_W  (TAP_W),
      .KIND   (KIND),
      .POLICY (POLICY)
   ) u_dec (
      .hold_en (hold_en),
      .ce      (ce),
      .inc     (inc),
      .load    (load),
      .tap_in  (tap_in),
      .base    (pend_q),
      .upd_vld (upd_vld),
      .upd_val (upd_val),
      .commit  (commit)
   );

   odly_tap_regs #(
      .TAP_W    (TAP_W),
      .INIT_VAL (INIT_VAL),
      .POLICY   (POLICY)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .dly_rst   (dly_rst),
      .hold_en   (hold_en),
      .upd_vld   (upd_vld),
      .upd_val   (upd_val),
      .commit    (commit),
      .line_edge (line_edge),
      .act_q     (act_q),
      .pend_q    (pend_q)
   );

   assign tap_mon = act_q;

endmodule

// File: rtl/odly_tap_ctrl_chk.sv
module odly_tap_ctrl_chk
   import odly_pkg::*;
#(
   parameter int          TAP_W    = 9,
   parameter int          INIT_TAP = 0,
   parameter dly_kind_e   KIND     = DLY_LOAD,
   parameter upd_policy_e POLICY   = UPD_NOW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dly_rst,
   input logic             hold_en,
   input logic             ce,
   input logic             inc,
   input logic             load,
   input logic [TAP_W-1:0] tap_in,
   input logic             line_data,
   input logic [TAP_W-1:0] tap_mon
);

   localparam int               TAP_MAX  = (1 << TAP_W) - 1;
   localparam int               INIT_SAT = (INIT_TAP > TAP_MAX) ? TAP_MAX : INIT_TAP;
   localparam logic [TAP_W-1:0] INIT_VAL = INIT_SAT[TAP_W-1:0];
   localparam logic [TAP_W-1:0] TAP_TOP  = '1;
   localparam logic [TAP_W-1:0] TAP_ONE  = TAP_W'(1);

   logic unused_chk;
   assign unused_chk = ^{inc, tap_in, line_data, load, ce};

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && !dly_rst) |=> $stable(tap_mon)); // R2

   AST_DLY_RST_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      dly_rst |=> (tap_mon == INIT_VAL)); // R6

   generate
      if (KIND == DLY_FIXED) begin : g_fixed
         AST_FIXED_CONST: assert property (@(posedge clk) disable iff (!rst_n)
            !dly_rst |=> (tap_mon == INIT_VAL)); // R5
      end

      if (KIND != DLY_FIXED && POLICY == UPD_NOW) begin : g_now
         AST_STEP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            (ce && !hold_en && !dly_rst && !(KIND == DLY_LOAD && load)) |=>
            ($past(inc) ?
               (tap_mon == (($past(tap_mon) == TAP_TOP) ? TAP_TOP : $past(tap_mon) + TAP_ONE)) :
               (tap_mon == (($past(tap_mon) == '0) ? '0 : $past(tap_mon) - TAP_ONE)))); // R10

         if (KIND == DLY_LOAD) begin : g_load
            AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
               (load && !hold_en && !dly_rst) |=> (tap_mon == $past(tap_in))); // R11
         end
      end

      if (POLICY == UPD_MANUAL) begin : g_man
         AST_MANUAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(load && ce) && !dly_rst) |=> $stable(tap_mon)); // R7
      end

      if (POLICY == UPD_EDGE) begin : g_edge
         AST_EDGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!dly_rst && line_data == $past(line_data)) |=> $stable(tap_mon)); // R8
      end
   endgenerate

endmodule

bind odly_tap_ctrl odly_tap_ctrl_chk #(
   .TAP_W    (TAP_W),
   .INIT_TAP (INIT_TAP),
   .KIND     (KIND),
   .POLICY   (POLICY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dly_rst   (dly_rst),
   .hold_en   (hold_en),
   .ce        (ce),
   .inc       (inc),
   .load      (load),
   .tap_in    (tap_in),
   .line_data (line_data),
   .tap_mon   (tap_mon)
);

// File: tb/tb_odly_tap_ctrl.sv
module tb_odly_tap_ctrl;
   import odly_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dly_rst = 1'b0;
   logic       hold_en = 1'b0;
   logic       ce = 1'b0;
   logic       inc = 1'b0;
   logic       load = 1'b0;
   logic [8:0] tap_in = '0;
   logic       line_data = 1'b0;

   logic [8:0] mon_ld, mon_st, mon_fx, mon_ed, mon_mn;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit model_on = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   // Load type, immediate; INIT 600 clamps to 511 (R9)
   odly_tap_ctrl #(.TAP_W(9), .INIT_TAP(600), .KIND(DLY_LOAD), .POLICY(UPD_NOW)) dut (
      .clk(clk), .rst_n(rst_n), .dly_rst(dly_rst), .hold_en(hold_en), .ce(ce), .inc(inc),
      .load(load), .tap_in(tap_in), .line_data(line_data), .tap_mon(mon_ld));
   odly_tap_ctrl #(.TAP_W(9), .INIT_TAP(3), .KIND(DLY_STEP), .POLICY(UPD_NOW)) dut_step (
      .clk(clk), .rst_n(rst_n), .dly_rst(dly_rst), .hold_en(hold_en), .ce(ce), .inc(inc),
      .load(load), .tap_in(tap_in), .line_data(line_data), .tap_mon(mon_st));
   odly_tap_ctrl #(.TAP_W(9), .INIT_TAP(77), .KIND(DLY_FIXED), .POLICY(UPD_NOW)) dut_fix (
      .clk(clk), .rst_n(rst_n), .dly_rst(dly_rst), .hold_en(hold_en), .ce(ce), .inc(inc),
      .load(load), .tap_in(tap_in), .line_data(line_data), .tap_mon(mon_fx));
   odly_tap_ctrl #(.TAP_W(9), .INIT_TAP(10), .KIND(DLY_LOAD), .POLICY(UPD_EDGE)) dut_edge (
      .clk(clk), .rst_n(rst_n), .dly_rst(dly_rst), .hold_en(hold_en), .ce(ce), .inc(inc),
      .load(load), .tap_in(tap_in), .line_data(line_data), .tap_mon(mon_ed));
   odly_tap_ctrl #(.TAP_W(9), .INIT_TAP(200), .KIND(DLY_LOAD), .POLICY(UPD_MANUAL)) dut_man (
      .clk(clk), .rst_n(rst_n), .dly_rst(dly_rst), .hold_en(hold_en), .ce(ce), .inc(inc),
      .load(load), .tap_in(tap_in), .line_data(line_data), .tap_mon(mon_mn));

   // ---------------- reference model built from the requirements ----------------
   logic [8:0] a_ld, p_ld, a_st, p_st, a_fx, p_fx, a_ed, p_ed, a_mn, p_mn;
   logic       line_prev;

   function automatic logic [8:0] sat_move(logic [8:0] b, logic up);
      if (up) return (b == 9'd511) ? b : b + 9'd1;
      else    return (b == 9'd0)   ? b : b - 9'd1;
   endfunction

   task automatic mstep(input dly_kind_e kind, input upd_policy_e pol, input logic [8:0] init,
                        input logic edg, inout logic [8:0] act, inout logic [8:0] pend);
      logic [8:0] old_pend;
      logic       req;
      logic [8:0] cand;
      old_pend = pend;
      if (dly_rst) begin act = init; pend = init; return; end     // R6
      if (kind == DLY_FIXED || hold_en) return;                     // R5, R2
      if (pol == UPD_MANUAL && load && ce) begin act = pend; return; end // R7
      req = 1'b0;
      cand = pend;
      if (kind == DLY_LOAD && load) begin req = 1'b1; cand = tap_in; end // R4, R11
      else if (ce) begin req = 1'b1; cand = sat_move(pend, inc); end     // R3, R10
      if (req) pend = cand;
      if (pol == UPD_NOW && req) act = cand;                        // R12
      if (pol == UPD_EDGE && edg) act = old_pend;                   // R8
   endtask

   task automatic model_init();
      a_ld = 9'd511; p_ld = 9'd511;
      a_st = 9'd3;   p_st = 9'd3;
      a_fx = 9'd77;  p_fx = 9'd77;
      a_ed = 9'd10;  p_ed = 9'd10;
      a_mn = 9'd200; p_mn = 9'd200;
      line_prev = 1'b0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_init();
      else begin
         logic edg;
         edg = (line_data != line_prev);
         mstep(DLY_LOAD,  UPD_NOW,    9'd511, edg, a_ld, p_ld);
         mstep(DLY_STEP,  UPD_NOW,    9'd3,   edg, a_st, p_st);
         mstep(DLY_FIXED, UPD_NOW,    9'd77,  edg, a_fx, p_fx);
         mstep(DLY_LOAD,  UPD_EDGE,   9'd10,  edg, a_ed, p_ed);
         mstep(DLY_LOAD,  UPD_MANUAL, 9'd200, edg, a_mn, p_mn);
         line_prev = line_data;
      end
   end

   task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // every-cycle comparison against the model (R1 plus the type/policy requirement)
   always @(negedge clk) begin
      if (model_on) begin
         chk("R4 load/immediate model", mon_ld, a_ld);
         chk("R3 step/immediate model", mon_st, a_st);
         chk("R5 fixed model", mon_fx, a_fx);
         chk("R8 data-edge model", mon_ed, a_ed);
         chk("R7 manual model", mon_mn, a_mn);
      end
   end

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
         finish_run();
      end
   end

   task automatic drive(input logic c, input logic i, input logic l, input logic [8:0] v,
                        input logic h, input logic dr, input int n);
      ce = c; inc = i; load = l; tap_in = v; hold_en = h; dly_rst = dr;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_init();
      repeat (3) @(negedge clk);
      // reset values (R1, R9)
      chk("R9 clamped init", mon_ld, 9'd511);
      chk("R9 init step", mon_st, 9'd3);
      chk("R9 init fixed", mon_fx, 9'd77);
      chk("R9 init edge", mon_ed, 9'd10);
      chk("R9 init manual", mon_mn, 9'd200);
      rst_n = 1'b1;
      model_on = 1'b1;

      drive(1'b1, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0, 4);
      chk("R10 floor saturation", mon_st, 9'd0);
      chk("R12 step reaches monitor", mon_ld, 9'd507);
      chk("R8 staged step not active", mon_ed, 9'd10);
      chk("R7 staged step not active", mon_mn, 9'd200);

      line_data = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 9'd0, 1'b0, 1'b0, 1);
      chk("R8 data edge commits", mon_ed, 9'd6);

      drive(1'b1, 1'b0, 1'b1, 9'd510, 1'b0, 1'b0, 1);
      chk("R11 load beats step", mon_ld, 9'd510);
      chk("R3 load ignored in step type", mon_st, 9'd0);
      chk("R7 load with enable commits", mon_mn, 9'd196);

      drive(1'b1, 1'b1, 1'b0, 9'd0, 1'b0, 1'b0, 3);
      chk("R10 ceiling saturation", mon_ld, 9'd511);
      chk("R3 step up", mon_st, 9'd3);
      chk("R7 no commit without load", mon_mn, 9'd196);

      drive(1'b1, 1'b0, 1'b1, 9'd5, 1'b1, 1'b0, 2);
      chk("R2 hold blocks load", mon_ld, 9'd511);
      chk("R2 hold blocks step", mon_st, 9'd3);
      chk("R5 fixed ignores strobes", mon_fx, 9'd77);

      drive(1'b1, 1'b1, 1'b1, 9'd40, 1'b1, 1'b1, 1);
      chk("R6 delay reset step", mon_st, 9'd3);
      chk("R6 delay reset manual", mon_mn, 9'd200);
      chk("R6 delay reset edge", mon_ed, 9'd10);
      chk("R6 delay reset load", mon_ld, 9'd511);

      // constrained random phase, checked each cycle by the model
      for (int n = 0; n < 4000; n++) begin
         logic [8:0] v;
         case ($urandom_range(0, 3))
            0: v = 9'd0;
            1: v = 9'd511;
            default: v = 9'($urandom_range(0, 511));
         endcase
         if ($urandom_range(0, 3) == 0) line_data = ~line_data;
         drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 3) == 0), v,
               ($urandom_range(0, 7) == 0), ($urandom_range(0, 31) == 0), 1);
      end
      finish_run();
   end

endmodule